// File: doc/BRIEF.md
# Front-Panel Tuning Menu Controller

This block is the navigation and tuning core behind a receiver's front panel. It takes single-cycle event pulses from the knob and buttons (increment, decrement, left, right, enter, escape). From them it keeps a menu position, a selected option index and a tuning frequency in hertz. From the top menu the operator picks one of four submenus. In the frequency submenu the knob retunes by a decade step, and left/right choose which digit is being tuned. In the mode, AGC and preamp submenus the knob walks through that setting's choices, and enter stores the choice.

Every accepted event also refreshes a synthesizer word equal to twice the tuning frequency. A local-oscillator synthesizer can therefore be driven directly from the output. Indices never wrap: each one stops at its lowest and highest legal value. Frequency tuning is clamped at both ends, so a large downward step can never underflow.

Top module: `tune_menu_fsm`

## Requirements
- R1: After reset the menu state is 0 (top menu), the option is 0, the frequency is FREQ_DEFAULT (7,074,000 Hz), the synthesizer word is twice that, and all three stored settings are 0.
- R2: In the top menu, increment or right adds one to the option, stopping at 4 (five menu states, coded top=0, frequency=1, mode=2, AGC=3, preamp=4).
- R3: In the top menu, decrement or left lowers the option by one while it is above 1; otherwise the option becomes 0.
- R4: Enter in the top menu moves to the state whose code equals the option. The option is then loaded with the stored setting for mode, AGC or preamp, or with 0 for the frequency and top states.
- R5: In the frequency state, increment adds step(option) and limits the result to FREQ_MAX (30,000,000 Hz). Steps for options 0..5 are 10,000,000 / 1,000,000 / 100,000 / 10,000 / 1,000 / 100 Hz, and option 6 has a step of 0.
- R6: In the frequency state, decrement subtracts the step when frequency > step + 100. Otherwise the frequency becomes FREQ_MIN (100 Hz).
- R7: In the frequency state, right and left move the option (digit) by one, saturating at 0 and 6.
- R8: In the mode, AGC and preamp submenus, increment/right and decrement/left move the option by one. The option saturates at 0 and at the count minus 1 (counts 4, 3 and 3).
- R9: Enter in a setting submenu stores the option as that setting. Escape does not store it. Both return to the top menu with the option set to the submenu's state code. Enter or escape in the frequency state returns with option 1.
- R10: The synthesizer word always equals twice the frequency and changes on the same clock edge as the event that changed the frequency. With no event pulse, state, option and frequency hold.
- R11: When several event pulses arrive in one cycle, only one acts, chosen by the priority enter > escape > increment > decrement > right > left.
- R12: Escape in the top menu changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_inc | input | 1 | Increment pulse (knob clockwise) |
| ev_dec | input | 1 | Decrement pulse (knob counter-clockwise) |
| ev_left | input | 1 | Left pulse |
| ev_right | input | 1 | Right pulse |
| ev_enter | input | 1 | Enter pulse |
| ev_esc | input | 1 | Escape pulse |
| menu_state | output | 3 | Current state code |
| option | output | 3 | Selected option / digit index |
| freq_hz | output | FREQ_W | Tuning frequency in Hz |
| synth_word | output | FREQ_W+1 | Twice the tuning frequency |
| mode_sel | output | 3 | Stored mode setting |
| agc_sel | output | 3 | Stored AGC setting |
| pre_sel | output | 3 | Stored preamp setting |

## Verification
Two kinds of event can meet in one clock: two or more button pulses, and an exit that must store a setting while it also moves the option to the submenu code. The bench raises pairs and triples of pulses together: increment with decrement, enter with increment, right with left, escape with enter, and decrement with left and right. It judges each case by whether the state, option and frequency match what the higher-priority event alone would give. The escape-with-enter case in the preamp submenu is then read back through the stored preamp setting, which shows that enter won and stored its value.

// File: rtl/tune_pkg.sv
package tune_pkg;

  localparam int OPT_W      = 3;
  localparam int NUM_STATES = 5;
  localparam int DIGIT_MAX  = 6;
  localparam int WIDE_W     = 40;

  typedef enum logic [2:0] {
    ST_MENU = 3'd0,
    ST_FREQ = 3'd1,
    ST_MODE = 3'd2,
    ST_AGC  = 3'd3,
    ST_PRE  = 3'd4
  } menu_st_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_ENTER, EV_ESC, EV_INC, EV_DEC, EV_RIGHT, EV_LEFT
  } ev_e;

  // Decade step per digit position; positions past the table give 0.
  function automatic logic [WIDE_W-1:0] step_of(input logic [OPT_W-1:0] digit);
    case (digit)
      3'd0:    step_of = WIDE_W'(10_000_000);
      3'd1:    step_of = WIDE_W'(1_000_000);
      3'd2:    step_of = WIDE_W'(100_000);
      3'd3:    step_of = WIDE_W'(10_000);
      3'd4:    step_of = WIDE_W'(1_000);
      3'd5:    step_of = WIDE_W'(100);
      default: step_of = '0;
    endcase
  endfunction

  function automatic logic [WIDE_W-1:0] freq_up(input logic [WIDE_W-1:0] f,
                                                input logic [WIDE_W-1:0] s,
                                                input logic [WIDE_W-1:0] hi);
    logic [WIDE_W-1:0] sum;
    sum = f + s;
    freq_up = (sum > hi) ? hi : sum;
  endfunction

  function automatic logic [WIDE_W-1:0] freq_down(input logic [WIDE_W-1:0] f,
                                                  input logic [WIDE_W-1:0] s,
                                                  input logic [WIDE_W-1:0] lo);
    freq_down = (f > s + lo) ? f - s : lo;
  endfunction

  function automatic logic [OPT_W-1:0] sat_inc(input logic [OPT_W-1:0] o,
                                               input logic [OPT_W-1:0] lim);
    sat_inc = (o < lim) ? o + 1'b1 : lim;
  endfunction

  function automatic logic [OPT_W-1:0] sat_dec(input logic [OPT_W-1:0] o);
    sat_dec = (o > 0) ? o - 1'b1 : '0;
  endfunction

endpackage

// File: rtl/tune_event_arb.sv
module tune_event_arb
  import tune_pkg::*;
(
  input  logic ev_inc,
  input  logic ev_dec,
  input  logic ev_left,
  input  logic ev_right,
  input  logic ev_enter,
  input  logic ev_esc,
  output ev_e  ev_sel,
  output logic ev_any
);
  always_comb begin
    if      (ev_enter) ev_sel = EV_ENTER;
    else if (ev_esc)   ev_sel = EV_ESC;
    else if (ev_inc)   ev_sel = EV_INC;
    else if (ev_dec)   ev_sel = EV_DEC;
    else if (ev_right) ev_sel = EV_RIGHT;
    else if (ev_left)  ev_sel = EV_LEFT;
    else               ev_sel = EV_NONE;
  end

  assign ev_any = (ev_sel != EV_NONE);
endmodule

// File: rtl/tune_freq_calc.sv
module tune_freq_calc
  import tune_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int FREQ_MAX = 30_000_000,
  parameter int FREQ_MIN = 100
) (
  input  logic [FREQ_W-1:0] freq,
  input  logic [OPT_W-1:0]  digit,
  input  logic              tune_up,
  input  logic              tune_down,
  output logic [FREQ_W-1:0] freq_nxt
);
  localparam logic [WIDE_W-1:0] HI_W = WIDE_W'(FREQ_MAX);
  localparam logic [WIDE_W-1:0] LO_W = WIDE_W'(FREQ_MIN);

  logic [WIDE_W-1:0] f_w, s_w, r_w;

  assign f_w = WIDE_W'(freq);
  assign s_w = step_of(digit);

  always_comb begin
    if (tune_up)        r_w = freq_up(f_w, s_w, HI_W);
    else if (tune_down) r_w = freq_down(f_w, s_w, LO_W);
    else                r_w = f_w;
  end

  assign freq_nxt = FREQ_W'(r_w);
endmodule

// File: rtl/tune_option_ctl.sv
module tune_option_ctl
  import tune_pkg::*;
#(
  parameter int MODE_CNT = 4,
  parameter int AGC_CNT  = 3,
  parameter int PRE_CNT  = 3
) (
  input  ev_e                  ev_sel,
  input  menu_st_e             st,
  input  logic [OPT_W-1:0]     opt,
  input  logic [3*OPT_W-1:0]   settings,
  output menu_st_e             st_nxt,
  output logic [OPT_W-1:0]     opt_nxt,
  output logic                 commit
);
  logic [OPT_W-1:0] lim;
  logic             in_setting;

  always_comb begin
    case (st)
      ST_MENU: lim = OPT_W'(NUM_STATES - 1);
      ST_FREQ: lim = OPT_W'(DIGIT_MAX);
      ST_MODE: lim = OPT_W'(MODE_CNT - 1);
      ST_AGC:  lim = OPT_W'(AGC_CNT - 1);
      ST_PRE:  lim = OPT_W'(PRE_CNT - 1);
      default: lim = '0;
    endcase
  end

  assign in_setting = (st == ST_MODE) || (st == ST_AGC) || (st == ST_PRE);

  always_comb begin
    st_nxt  = st;
    opt_nxt = opt;
    commit  = 1'b0;
    case (ev_sel)
      EV_ENTER: begin
        if (st == ST_MENU) begin
          st_nxt = menu_st_e'(opt);
          case (opt)
            3'd2:    opt_nxt = settings[0*OPT_W +: OPT_W];
            3'd3:    opt_nxt = settings[1*OPT_W +: OPT_W];
            3'd4:    opt_nxt = settings[2*OPT_W +: OPT_W];
            default: opt_nxt = '0;
          endcase
        end else begin
          commit  = in_setting;
          st_nxt  = ST_MENU;
          opt_nxt = OPT_W'(st);
        end
      end
      EV_ESC: begin
        if (st != ST_MENU) begin
          st_nxt  = ST_MENU;
          opt_nxt = OPT_W'(st);
        end
      end
      EV_INC:   if (st != ST_FREQ) opt_nxt = sat_inc(opt, lim);
      EV_DEC:   if (st != ST_FREQ) opt_nxt = sat_dec(opt);
      EV_RIGHT: opt_nxt = sat_inc(opt, lim);
      EV_LEFT:  opt_nxt = sat_dec(opt);
      default: ;
    endcase
  end
endmodule

// File: rtl/tune_menu_fsm.sv
module tune_menu_fsm
  import tune_pkg::*;
#(
  parameter int FREQ_W       = 32,
  parameter int FREQ_MAX     = 30_000_000,
  parameter int FREQ_MIN     = 100,
  parameter int FREQ_DEFAULT = 7_074_000,
  parameter int MODE_CNT     = 4,
  parameter int AGC_CNT      = 3,
  parameter int PRE_CNT      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_inc,
  input  logic              ev_dec,
  input  logic              ev_left,
  input  logic              ev_right,
  input  logic              ev_enter,
  input  logic              ev_esc,
  output logic [2:0]        menu_state,
  output logic [2:0]        option,
  output logic [FREQ_W-1:0] freq_hz,
  output logic [FREQ_W:0]   synth_word,
  output logic [2:0]        mode_sel,
  output logic [2:0]        agc_sel,
  output logic [2:0]        pre_sel
);
  localparam int NSET  = 3;
  localparam int SYN_W = FREQ_W + 1;

  ev_e              ev_sel;
  logic             ev_any;
  menu_st_e         st_q, st_n;
  logic [OPT_W-1:0] opt_q, opt_n;
  logic             commit;
  logic             tune_up, tune_down;
  logic [FREQ_W-1:0] freq_q, freq_nxt;
  logic [SYN_W-1:0]  syn_q;
  logic [OPT_W-1:0]  set_q [NSET];
  logic [NSET*OPT_W-1:0] set_flat;

  tune_event_arb u_arb (
    .ev_inc(ev_inc), .ev_dec(ev_dec), .ev_left(ev_left), .ev_right(ev_right),
    .ev_enter(ev_enter), .ev_esc(ev_esc), .ev_sel(ev_sel), .ev_any(ev_any)
  );

  tune_option_ctl #(.MODE_CNT(MODE_CNT), .AGC_CNT(AGC_CNT), .PRE_CNT(PRE_CNT)) u_opt (
    .ev_sel(ev_sel), .st(st_q), .opt(opt_q), .settings(set_flat),
    .st_nxt(st_n), .opt_nxt(opt_n), .commit(commit)
  );

  assign tune_up   = (ev_sel == EV_INC) && (st_q == ST_FREQ);
  assign tune_down = (ev_sel == EV_DEC) && (st_q == ST_FREQ);

  tune_freq_calc #(.FREQ_W(FREQ_W), .FREQ_MAX(FREQ_MAX), .FREQ_MIN(FREQ_MIN)) u_frq (
    .freq(freq_q), .digit(opt_q), .tune_up(tune_up), .tune_down(tune_down),
    .freq_nxt(freq_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_MENU;
      opt_q  <= '0;
      freq_q <= FREQ_W'(FREQ_DEFAULT);
      syn_q  <= SYN_W'(FREQ_DEFAULT) << 1;
    end else if (ev_any) begin
      st_q   <= st_n;
      opt_q  <= opt_n;
      freq_q <= freq_nxt;
      syn_q  <= {freq_nxt, 1'b0};
    end
  end

  // One stored setting per selectable submenu (mode, AGC, preamp).
  for (genvar g = 0; g < NSET; g++) begin : g_set
    logic hit;
    assign hit = commit && (st_q == menu_st_e'(3'(int'(ST_MODE) + g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   set_q[g] <= '0;
      else if (hit) set_q[g] <= opt_q;
    end
    assign set_flat[g*OPT_W +: OPT_W] = set_q[g];
  end

  assign menu_state = st_q;
  assign option     = opt_q;
  assign freq_hz    = freq_q;
  assign synth_word = syn_q;
  assign mode_sel   = set_q[0];
  assign agc_sel    = set_q[1];
  assign pre_sel    = set_q[2];
endmodule

// File: rtl/tune_menu_chk.sv
module tune_menu_chk
  import tune_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int FREQ_MAX = 30_000_000,
  parameter int FREQ_MIN = 100,
  parameter int MODE_CNT = 4,
  parameter int AGC_CNT  = 3,
  parameter int PRE_CNT  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input ev_e               ev_sel,
  input logic              ev_any,
  input logic [2:0]        menu_state,
  input logic [2:0]        option,
  input logic [FREQ_W-1:0] freq_hz,
  input logic [FREQ_W:0]   synth_word
);
  logic [2:0] bound;
  always_comb begin
    case (menu_state)
      3'd0:    bound = 3'(NUM_STATES - 1);
      3'd1:    bound = 3'(DIGIT_MAX);
      3'd2:    bound = 3'(MODE_CNT - 1);
      3'd3:    bound = 3'(AGC_CNT - 1);
      3'd4:    bound = 3'(PRE_CNT - 1);
      default: bound = '0;
    endcase
  end

  // R10
  synth_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    synth_word == {freq_hz, 1'b0});

  // R5
  freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_hz <= FREQ_W'(FREQ_MAX)) && (freq_hz >= FREQ_W'(FREQ_MIN)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_any |=> $stable(freq_hz) && $stable(option) && $stable(menu_state));

  // R9
  exit_menu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel == EV_ESC && menu_state != 3'd0) |=> menu_state == 3'd0);

  // R6
  dec_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel == EV_DEC && menu_state == 3'd1) |=> freq_hz <= $past(freq_hz));

  // R8
  option_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    option <= bound);
endmodule

bind tune_menu_fsm tune_menu_chk #(
  .FREQ_W(FREQ_W), .FREQ_MAX(FREQ_MAX), .FREQ_MIN(FREQ_MIN),
  .MODE_CNT(MODE_CNT), .AGC_CNT(AGC_CNT), .PRE_CNT(PRE_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_sel(ev_sel), .ev_any(ev_any),
  .menu_state(menu_state), .option(option), .freq_hz(freq_hz),
  .synth_word(synth_word)
);

// File: tb/tb_tune_menu_fsm.sv
module tb_tune_menu_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int DEF_F = 7_074_000;

  // event bits: [5] enter [4] escape [3] inc [2] dec [1] right [0] left
  localparam logic [5:0] EN = 6'b100000, ES = 6'b010000, IN = 6'b001000,
                         DE = 6'b000100, RI = 6'b000010, LE = 6'b000001;

  // {requirement, events, state, option, frequency}
  localparam logic [47:0] VEC [61] = '{
    {4'd2,  IN, 3'd0, 3'd1, 32'd7074000},   // R2
    {4'd2,  RI, 3'd0, 3'd2, 32'd7074000},
    {4'd2,  IN, 3'd0, 3'd3, 32'd7074000},
    {4'd2,  IN, 3'd0, 3'd4, 32'd7074000},
    {4'd2,  IN, 3'd0, 3'd4, 32'd7074000},   // R2 saturate
    {4'd3,  DE, 3'd0, 3'd3, 32'd7074000},   // R3
    {4'd3,  LE, 3'd0, 3'd2, 32'd7074000},
    {4'd3,  DE, 3'd0, 3'd1, 32'd7074000},
    {4'd3,  DE, 3'd0, 3'd0, 32'd7074000},
    {4'd3,  DE, 3'd0, 3'd0, 32'd7074000},
    {4'd12, ES, 3'd0, 3'd0, 32'd7074000},   // R12
    {4'd2,  IN, 3'd0, 3'd1, 32'd7074000},
    {4'd4,  EN, 3'd1, 3'd0, 32'd7074000},   // R4
    {4'd5,  IN, 3'd1, 3'd0, 32'd17074000},  // R5
    {4'd5,  IN, 3'd1, 3'd0, 32'd27074000},
    {4'd5,  IN, 3'd1, 3'd0, 32'd30000000},  // R5 clamp
    {4'd7,  RI, 3'd1, 3'd1, 32'd30000000},
    {4'd6,  DE, 3'd1, 3'd1, 32'd29000000},  // R6
    {4'd7,  RI, 3'd1, 3'd2, 32'd29000000},  // R7
    {4'd7,  RI, 3'd1, 3'd3, 32'd29000000},
    {4'd7,  RI, 3'd1, 3'd4, 32'd29000000},
    {4'd7,  RI, 3'd1, 3'd5, 32'd29000000},
    {4'd7,  RI, 3'd1, 3'd6, 32'd29000000},
    {4'd7,  RI, 3'd1, 3'd6, 32'd29000000},
    {4'd5,  IN, 3'd1, 3'd6, 32'd29000000},  // R5 zero step
    {4'd7,  LE, 3'd1, 3'd5, 32'd29000000},
    {4'd6,  DE, 3'd1, 3'd5, 32'd28999900},
    {4'd7,  LE, 3'd1, 3'd4, 32'd28999900},
    {4'd7,  LE, 3'd1, 3'd3, 32'd28999900},
    {4'd7,  LE, 3'd1, 3'd2, 32'd28999900},
    {4'd7,  LE, 3'd1, 3'd1, 32'd28999900},
    {4'd7,  LE, 3'd1, 3'd0, 32'd28999900},
    {4'd7,  LE, 3'd1, 3'd0, 32'd28999900},
    {4'd6,  DE, 3'd1, 3'd0, 32'd18999900},
    {4'd6,  DE, 3'd1, 3'd0, 32'd8999900},
    {4'd6,  DE, 3'd1, 3'd0, 32'd100},       // R6 floor
    {4'd6,  DE, 3'd1, 3'd0, 32'd100},
    {4'd5,  IN, 3'd1, 3'd0, 32'd10000100},
    {4'd9,  ES, 3'd0, 3'd1, 32'd10000100},  // R9
    {4'd2,  RI, 3'd0, 3'd2, 32'd10000100},
    {4'd4,  EN, 3'd2, 3'd0, 32'd10000100},
    {4'd8,  IN, 3'd2, 3'd1, 32'd10000100},  // R8
    {4'd8,  IN, 3'd2, 3'd2, 32'd10000100},
    {4'd8,  IN, 3'd2, 3'd3, 32'd10000100},
    {4'd8,  IN, 3'd2, 3'd3, 32'd10000100},
    {4'd9,  EN, 3'd0, 3'd2, 32'd10000100},
    {4'd4,  EN, 3'd2, 3'd3, 32'd10000100},  // R4 reload
    {4'd8,  DE, 3'd2, 3'd2, 32'd10000100},
    {4'd9,  ES, 3'd0, 3'd2, 32'd10000100},
    {4'd2,  IN, 3'd0, 3'd3, 32'd10000100},
    {4'd4,  EN, 3'd3, 3'd0, 32'd10000100},
    {4'd8,  LE, 3'd3, 3'd0, 32'd10000100},
    {4'd8,  RI, 3'd3, 3'd1, 32'd10000100},
    {4'd8,  RI, 3'd3, 3'd2, 32'd10000100},
    {4'd8,  RI, 3'd3, 3'd2, 32'd10000100},
    {4'd9,  ES, 3'd0, 3'd3, 32'd10000100},
    {4'd11, IN|DE, 3'd0, 3'd4, 32'd10000100},     // R11
    {4'd11, EN|IN, 3'd4, 3'd0, 32'd10000100},
    {4'd11, RI|LE, 3'd4, 3'd1, 32'd10000100},
    {4'd11, ES|EN, 3'd0, 3'd4, 32'd10000100},
    {4'd11, DE|LE|RI, 3'd0, 3'd3, 32'd10000100}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_inc = 0, ev_dec = 0, ev_left = 0, ev_right = 0, ev_enter = 0, ev_esc = 0;
  logic [2:0]  menu_state, option, mode_sel, agc_sel, pre_sel;
  logic [31:0] freq_hz;
  logic [32:0] synth_word;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_menu_fsm dut (
    .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .ev_dec(ev_dec),
    .ev_left(ev_left), .ev_right(ev_right), .ev_enter(ev_enter), .ev_esc(ev_esc),
    .menu_state(menu_state), .option(option), .freq_hz(freq_hz),
    .synth_word(synth_word), .mode_sel(mode_sel), .agc_sel(agc_sel), .pre_sel(pre_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic [5:0] e);
    @(negedge clk);
    {ev_enter, ev_esc, ev_inc, ev_dec, ev_right, ev_left} = e;
    @(negedge clk);
    {ev_enter, ev_esc, ev_inc, ev_dec, ev_right, ev_left} = '0;
  endtask

  task automatic check_reset_state();
    chk("R1", "state",  64'(menu_state), 0);
    chk("R1", "option", 64'(option), 0);
    chk("R1", "freq",   64'(freq_hz), 64'(DEF_F));
    chk("R1", "synth",  64'(synth_word), 64'(2 * DEF_F));
    chk("R1", "settings", 64'({mode_sel, agc_sel, pre_sel}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    for (int i = 0; i < 61; i++) begin
      logic [47:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[47:44], i);
      pulse(v[43:38]);
      chk(tag, "state",  64'(menu_state), 64'(v[37:35]));
      chk(tag, "option", 64'(option), 64'(v[34:32]));
      chk(tag, "freq",   64'(freq_hz), 64'(v[31:0]));
      // R10: synthesizer word is twice the frequency
      chk("R10", "synth", 64'(synth_word), 64'(v[31:0]) * 2);
    end

    // R9: enter stored mode 3 and preamp 1; escape left AGC at 0
    chk("R9", "mode_sel", 64'(mode_sel), 3);
    chk("R9", "agc_sel",  64'(agc_sel), 0);
    chk("R9", "pre_sel",  64'(pre_sel), 1);

    // R10: with no pulses, everything holds
    repeat (6) @(negedge clk);
    chk("R10", "idle state",  64'(menu_state), 0);
    chk("R10", "idle option", 64'(option), 3);
    chk("R10", "idle freq",   64'(freq_hz), 10000100);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule